// File: doc/BRIEF.md
# Dual-Channel Disk Controller Register File

This block is the memory-mapped register file of a two-channel disk controller. A host reaches it over a simple 32-bit read/write bus that decodes a 512-byte window. Each request carries a word-aligned byte address and four byte enables. For each channel the block holds a DMA command byte, a DMA status byte, a 6-bit vendor data byte, a descriptor-table address, a link-control word and an interrupt-enable field. It also exposes a read-only configuration/status word and a link-status word. Two combined-view words pack the command, status and interrupt flags of both channels into one read.

The block samples one interrupt input per channel into a flag. It drives a single level-sensitive interrupt output from those flags. It sends each command write to the DMA engine as a one-cycle strobe that carries the written byte. A link-control write with bit 0 set sends a one-cycle reset pulse to that channel, and the same pulse appears once on both channels as reset is released. Accesses to the two task-file windows are not served here. They are signalled on pass-through select outputs.

Top module: `dual_chan_regs`

## Requirements
- R1: Read data and a valid flag appear in the cycle after a read request. Unmapped offsets, and requests whose address bits [1:0] are not zero, read 0 and ignore writes.
- R2: Channel 0 uses word 0x00 and channel 1 uses word 0x08. In each word, lane 0 is the command byte (only bits 3 and 0 are kept), lane 1 is the vendor byte (low 6 bits kept), lane 2 is the status byte, and lane 3 reads 0. The descriptor address is at 0x04 and 0x0C, and each of its bytes is written under its own byte enable.
- R3: A status write loads bits 6:5 from the data, clears bits 2:1 where the data bit is 1, and leaves bit 0 as it was. Bits 7 and 4:3 always read 0.
- R4: Status bit 0 follows the channel's DMA-active input, one cycle late. Status bits 2 and 1 are set by the channel's interrupt-set and error-set inputs, and a set wins over a clear in the same cycle.
- R5: Writes to word 0x10 reach the command, vendor and status bytes of channel 0. Writes to word 0x18 reach those bytes of channel 1.
- R6: A read of 0x10 returns the channel 0 command in bits 7:0, with these flags added: channel 0 interrupt flag at bit 4, channel 1 interrupt flag at bit 6, channel 1 status bit 2 at bit 14. Channel 0 status is at bits 23:16 and channel 1 status at bits 31:24.
- R7: A read of 0x18 returns the channel 1 command with the channel 1 interrupt flag at bit 4 and channel 1 status at bits 23:16.
- R8: The configuration words at 0xA0 (channel 0) and 0xE0 (channel 1) read 0x6515 in bits 31:16. Bit 11 is the channel's interrupt flag, which takes the interrupt input level one cycle later. All other bits read 0.
- R9: The interrupt output is high exactly when either channel's interrupt flag is set.
- R10: Link control at 0x100 and 0x180 keeps the low 12 bits of a write. A write with byte enable 0 active and data bit 0 high gives a one-cycle reset pulse on that channel in the next cycle. Both pulses are high in the first cycle after reset.
- R11: Interrupt enable at 0x148 and 0x1C8 stores data bits 31:16 masked with 0x3EED. A read returns the stored value in bits 31:16.
- R12: Link status at 0x104 and 0x184 reads 0x113 while the channel's device-present input is high, and 0 otherwise.
- R13: A command write gives a one-cycle strobe on that channel in the next cycle. The full written byte appears on the channel's command-data lane.
- R14: A request to words 0x80–0x8B selects task-file channel 0 and a request to words 0xC0–0xCB selects channel 1, in the same cycle. The write flag marks writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 9 | Byte address, word aligned |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| irq_in_i | input | 2 | Per-channel interrupt input levels |
| bm_int_set_i | input | 2 | Per-channel set of status bit 2 |
| bm_err_set_i | input | 2 | Per-channel set of status bit 1 |
| dma_active_i | input | 2 | Per-channel DMA-active level for status bit 0 |
| dev_present_i | input | 2 | Per-channel device-present level |
| irq_o | output | 1 | Combined interrupt level |
| chan_rst_o | output | 2 | Per-channel reset pulse |
| cmd_stb_o | output | 2 | Per-channel command-write strobe |
| cmd_data_o | output | 16 | Written command byte, channel 1 in bits 15:8 |
| tf_sel_o | output | 2 | Task-file window select per channel |
| tf_we_o | output | 1 | Task-file access is a write |

## Verification
The hardest case to reach is a status write that tries to clear bit 1 in the same cycle that the error-set input raises it. The stimulus first sets that bit through the input, then drives the bus write and the set pulse together in one cycle and reads back that the bit survived. The combined views depend on four separate state sources. The bench builds them up in order: command writes, a status write through an alias, a set pulse on the other channel and then the interrupt inputs. Each read of the packed word is then preceded by a known change in just one of those flags.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int WA_W   = ADDR_W - 2;
  localparam int N_CH   = 2;

  localparam logic [WA_W-1:0] W_GRP0   = 7'h00;
  localparam logic [WA_W-1:0] W_DT0    = 7'h01;
  localparam logic [WA_W-1:0] W_GRP1   = 7'h02;
  localparam logic [WA_W-1:0] W_DT1    = 7'h03;
  localparam logic [WA_W-1:0] W_MIX0   = 7'h04;
  localparam logic [WA_W-1:0] W_MIX1   = 7'h06;
  localparam logic [WA_W-1:0] W_TF0_LO = 7'h20;
  localparam logic [WA_W-1:0] W_TF0_HI = 7'h22;
  localparam logic [WA_W-1:0] W_CFG0   = 7'h28;
  localparam logic [WA_W-1:0] W_TF1_LO = 7'h30;
  localparam logic [WA_W-1:0] W_TF1_HI = 7'h32;
  localparam logic [WA_W-1:0] W_CFG1   = 7'h38;
  localparam logic [WA_W-1:0] W_LC0    = 7'h40;
  localparam logic [WA_W-1:0] W_LS0    = 7'h41;
  localparam logic [WA_W-1:0] W_IE0    = 7'h52;
  localparam logic [WA_W-1:0] W_LC1    = 7'h60;
  localparam logic [WA_W-1:0] W_LS1    = 7'h61;
  localparam logic [WA_W-1:0] W_IE1    = 7'h72;

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  vd;
    logic [7:0]  st;
    logic [31:0] dt;
    logic [15:0] lc;
    logic [15:0] ie;
    logic        irq;
  } chan_regs_t;

  // bits 6:5 plain, 2:1 write-1-to-clear with set priority, 0 from engine
  function automatic logic [7:0] st_next(input logic [7:0] cur, input logic [7:0] w,
                                         input logic we, input logic iset,
                                         input logic eset, input logic act);
    logic [7:0] n;
    n = cur;
    if (we) begin
      n      = 8'h00;
      n[6:5] = w[6:5];
      n[2]   = cur[2] & ~w[2];
      n[1]   = cur[1] & ~w[1];
    end
    n[2] = n[2] | iset;
    n[1] = n[1] | eset;
    n[0] = act;
    return n;
  endfunction
endpackage

// File: rtl/dcr_chan.sv
module dcr_chan
  import dcr_pkg::*;
#(
  parameter logic [7:0]  CMD_MASK = 8'h09,
  parameter int          VD_W     = 6,
  parameter int          LC_W     = 12,
  parameter logic [15:0] IEN_MASK = 16'h3EED
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cmd_we_i,
  input  logic              vd_we_i,
  input  logic              st_we_i,
  input  logic [BE_W-1:0]   dt_we_i,
  input  logic [1:0]        lc_we_i,
  input  logic [1:0]        ie_we_i,
  input  logic              irq_i,
  input  logic              int_set_i,
  input  logic              err_set_i,
  input  logic              act_i,
  output chan_regs_t        regs_o,
  output logic              rst_pulse_o,
  output logic              cmd_stb_o,
  output logic [7:0]        cmd_byte_o
);
  localparam logic [7:0]  VD_MASK = 8'((1 << VD_W) - 1);
  localparam logic [15:0] LC_MASK = 16'((1 << LC_W) - 1);

  logic [7:0]  cmd_q, vd_q, st_q;
  logic [31:0] dt_q;
  logic [15:0] lc_q, ie_q;
  logic        irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      vd_q        <= '0;
      st_q        <= '0;
      dt_q        <= '0;
      lc_q        <= '0;
      ie_q        <= '0;
      irq_q       <= 1'b0;
      rst_pulse_o <= 1'b1;
      cmd_stb_o   <= 1'b0;
      cmd_byte_o  <= '0;
    end else begin
      if (cmd_we_i) cmd_q <= wdata_i[7:0] & CMD_MASK;
      if (vd_we_i)  vd_q  <= wdata_i[15:8] & VD_MASK;
      st_q <= st_next(st_q, wdata_i[23:16], st_we_i, int_set_i, err_set_i, act_i);
      for (int b = 0; b < BE_W; b++) begin
        if (dt_we_i[b]) dt_q[8*b +: 8] <= wdata_i[8*b +: 8];
      end
      if (lc_we_i[0]) lc_q[7:0]  <= wdata_i[7:0] & LC_MASK[7:0];
      if (lc_we_i[1]) lc_q[15:8] <= wdata_i[15:8] & LC_MASK[15:8];
      if (ie_we_i[0]) ie_q[7:0]  <= wdata_i[23:16] & IEN_MASK[7:0];
      if (ie_we_i[1]) ie_q[15:8] <= wdata_i[31:24] & IEN_MASK[15:8];
      irq_q       <= irq_i;
      rst_pulse_o <= lc_we_i[0] & wdata_i[0];
      cmd_stb_o   <= cmd_we_i;
      if (cmd_we_i) cmd_byte_o <= wdata_i[7:0];
    end
  end

  assign regs_o = '{cmd: cmd_q, vd: vd_q, st: st_q, dt: dt_q, lc: lc_q, ie: ie_q, irq: irq_q};
endmodule

// File: rtl/dcr_rd_mux.sv
module dcr_rd_mux
  import dcr_pkg::*;
#(
  parameter logic [15:0] CFG_ID  = 16'h6515,
  parameter logic [31:0] LINK_UP = 32'h0000_0113
) (
  input  logic [WA_W-1:0]        wa_i,
  input  chan_regs_t [N_CH-1:0]  regs_i,
  input  logic [N_CH-1:0]        present_i,
  output logic [DATA_W-1:0]      data_o
);
  logic [7:0] mix0_cmd, mix1_cmd;

  assign mix0_cmd = regs_i[0].cmd | {1'b0, regs_i[1].irq, 1'b0, regs_i[0].irq, 4'h0};
  assign mix1_cmd = regs_i[1].cmd | {3'b000, regs_i[1].irq, 4'h0};

  always_comb begin
    case (wa_i)
      W_GRP0: data_o = {8'h00, regs_i[0].st, regs_i[0].vd, regs_i[0].cmd};
      W_DT0:  data_o = regs_i[0].dt;
      W_GRP1: data_o = {8'h00, regs_i[1].st, regs_i[1].vd, regs_i[1].cmd};
      W_DT1:  data_o = regs_i[1].dt;
      W_MIX0: data_o = {regs_i[1].st, regs_i[0].st, 1'b0, regs_i[1].st[2], 6'h00, mix0_cmd};
      W_MIX1: data_o = {8'h00, regs_i[1].st, 8'h00, mix1_cmd};
      W_CFG0: data_o = {CFG_ID, 4'h0, regs_i[0].irq, 11'h000};
      W_CFG1: data_o = {CFG_ID, 4'h0, regs_i[1].irq, 11'h000};
      W_LC0:  data_o = {16'h0000, regs_i[0].lc};
      W_LC1:  data_o = {16'h0000, regs_i[1].lc};
      W_LS0:  data_o = present_i[0] ? LINK_UP : '0;
      W_LS1:  data_o = present_i[1] ? LINK_UP : '0;
      W_IE0:  data_o = {regs_i[0].ie, 16'h0000};
      W_IE1:  data_o = {regs_i[1].ie, 16'h0000};
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_chan_regs.sv
module dual_chan_regs
  import dcr_pkg::*;
#(
  parameter logic [15:0] CFG_ID   = 16'h6515,
  parameter logic [31:0] LINK_UP  = 32'h0000_0113,
  parameter logic [15:0] IEN_MASK = 16'h3EED,
  parameter logic [7:0]  CMD_MASK = 8'h09,
  parameter int          VD_W     = 6,
  parameter int          LC_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic [N_CH-1:0]   irq_in_i,
  input  logic [N_CH-1:0]   bm_int_set_i,
  input  logic [N_CH-1:0]   bm_err_set_i,
  input  logic [N_CH-1:0]   dma_active_i,
  input  logic [N_CH-1:0]   dev_present_i,
  output logic              irq_o,
  output logic [N_CH-1:0]   chan_rst_o,
  output logic [N_CH-1:0]   cmd_stb_o,
  output logic [8*N_CH-1:0] cmd_data_o,
  output logic [N_CH-1:0]   tf_sel_o,
  output logic              tf_we_o
);
  logic [WA_W-1:0]         wa;
  logic                    acc, wr, rd;
  chan_regs_t [N_CH-1:0]   regs;
  logic [N_CH-1:0]         irq_flags;
  logic [DATA_W-1:0]       rd_data;

  assign wa  = addr_i[ADDR_W-1:2];
  assign acc = req_i & (addr_i[1:0] == 2'b00);
  assign wr  = acc & we_i;
  assign rd  = acc & ~we_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [WA_W-1:0] GRP   = (c == 0) ? W_GRP0 : W_GRP1;
    localparam logic [WA_W-1:0] MIX   = (c == 0) ? W_MIX0 : W_MIX1;
    localparam logic [WA_W-1:0] DT    = (c == 0) ? W_DT0  : W_DT1;
    localparam logic [WA_W-1:0] LC    = (c == 0) ? W_LC0  : W_LC1;
    localparam logic [WA_W-1:0] IE    = (c == 0) ? W_IE0  : W_IE1;
    localparam logic [WA_W-1:0] TF_LO = (c == 0) ? W_TF0_LO : W_TF1_LO;
    localparam logic [WA_W-1:0] TF_HI = (c == 0) ? W_TF0_HI : W_TF1_HI;

    logic hit_byte;
    assign hit_byte = wr & ((wa == GRP) | (wa == MIX));

    dcr_chan #(
      .CMD_MASK(CMD_MASK),
      .VD_W    (VD_W),
      .LC_W    (LC_W),
      .IEN_MASK(IEN_MASK)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wdata_i    (wdata_i),
      .cmd_we_i   (hit_byte & be_i[0]),
      .vd_we_i    (hit_byte & be_i[1]),
      .st_we_i    (hit_byte & be_i[2]),
      .dt_we_i    ({BE_W{wr & (wa == DT)}} & be_i),
      .lc_we_i    ({2{wr & (wa == LC)}} & be_i[1:0]),
      .ie_we_i    ({2{wr & (wa == IE)}} & be_i[3:2]),
      .irq_i      (irq_in_i[c]),
      .int_set_i  (bm_int_set_i[c]),
      .err_set_i  (bm_err_set_i[c]),
      .act_i      (dma_active_i[c]),
      .regs_o     (regs[c]),
      .rst_pulse_o(chan_rst_o[c]),
      .cmd_stb_o  (cmd_stb_o[c]),
      .cmd_byte_o (cmd_data_o[8*c +: 8])
    );

    assign irq_flags[c] = regs[c].irq;
    assign tf_sel_o[c]  = acc & (wa >= TF_LO) & (wa <= TF_HI);
  end

  assign irq_o   = |irq_flags;
  assign tf_we_o = we_i & (|tf_sel_o);

  dcr_rd_mux #(
    .CFG_ID (CFG_ID),
    .LINK_UP(LINK_UP)
  ) u_rd_mux (
    .wa_i     (wa),
    .regs_i   (regs),
    .present_i(dev_present_i),
    .data_o   (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= req_i & ~we_i;
      rdata_o  <= rd ? rd_data : '0;
    end
  end
endmodule

// File: rtl/dual_chan_regs_chk.sv
module dual_chan_regs_chk
  import dcr_pkg::*;
#(
  parameter logic [15:0] CFG_ID   = 16'h6515,
  parameter logic [15:0] IEN_MASK = 16'h3EED
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BE_W-1:0]   be_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic [N_CH-1:0]   irq_in_i,
  input logic              irq_o,
  input logic [N_CH-1:0]   chan_rst_o,
  input logic [N_CH-1:0]   cmd_stb_o
);
  logic [WA_W-1:0] wa;
  assign wa = addr_i[ADDR_W-1:2];

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (rvalid_o == $past(req_i && !we_i))); // R1

  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rst_ni) && $past(req_i && addr_i[1:0] == 2'b00 && (wa == W_GRP0 || wa == W_GRP1)))
    |-> (rdata_o[31:23] == 9'h000 && rdata_o[20:19] == 2'b00)); // R3

  AST_CFG_ID_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rst_ni) && $past(req_i && addr_i[1:0] == 2'b00 && (wa == W_CFG0 || wa == W_CFG1)))
    |-> (rdata_o[31:16] == CFG_ID && rdata_o[15:12] == 4'h0 && rdata_o[10:0] == 11'h000)); // R8

  AST_IRQ_OR_INPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (irq_o == (|$past(irq_in_i)))); // R9

  AST_CH0_RST_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && chan_rst_o[0])
    |-> $past(req_i && we_i && addr_i == 9'h100 && be_i[0] && wdata_i[0])); // R10

  AST_CH1_RST_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && chan_rst_o[1])
    |-> $past(req_i && we_i && addr_i == 9'h180 && be_i[0] && wdata_i[0])); // R10

  AST_IEN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(rst_ni) && $past(req_i && addr_i[1:0] == 2'b00 && (wa == W_IE0 || wa == W_IE1)))
    |-> ((rdata_o[31:16] & ~IEN_MASK) == 16'h0000 && rdata_o[15:0] == 16'h0000)); // R11

  AST_CMD_STB_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && cmd_stb_o[0])
    |-> $past(req_i && we_i && be_i[0] && (addr_i == 9'h000 || addr_i == 9'h010))); // R13
endmodule

bind dual_chan_regs dual_chan_regs_chk #(
  .CFG_ID  (CFG_ID),
  .IEN_MASK(IEN_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .be_i      (be_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rvalid_o  (rvalid_o),
  .irq_in_i  (irq_in_i),
  .irq_o     (irq_o),
  .chan_rst_o(chan_rst_o),
  .cmd_stb_o (cmd_stb_o)
);

// File: tb/dual_chan_regs_tb_top.sv
module dual_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [1:0]  irq_in = '0, int_set = '0, err_set = '0, act = '0, present = '0;
  logic        irq_o;
  logic [1:0]  chan_rst_o, cmd_stb_o, tf_sel_o;
  logic [15:0] cmd_data_o;
  logic        tf_we_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dual_chan_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .irq_in_i(irq_in),
    .bm_int_set_i(int_set), .bm_err_set_i(err_set), .dma_active_i(act),
    .dev_present_i(present), .irq_o(irq_o), .chan_rst_o(chan_rst_o),
    .cmd_stb_o(cmd_stb_o), .cmd_data_o(cmd_data_o), .tf_sel_o(tf_sel_o), .tf_we_o(tf_we_o)
  );

  task automatic chk(input logic [31:0] act_v, input logic [31:0] exp_v, input string tag);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(ref logic [1:0] sig, input logic [1:0] v);
    @(negedge clk);
    sig = v;
    @(negedge clk);
    sig = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: unexpected rvalid, actual %h expected none", rdata_o);
      end else begin
        chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk(32'(chan_rst_o), 32'h3, "R10 reset pulse after reset");
    @(negedge clk);
    chk(32'(chan_rst_o), 32'h0, "R10 reset pulse ends");
    chk(32'(irq_o), 32'h0, "R9 irq idle after reset");
    rd(9'h000, 32'h0, "R2 reset group0");
    rd(9'h0A0, 32'h6515_0000, "R8 cfg0 reset");
    rd(9'h104, 32'h0, "R12 link absent");

    // R2 / R13 command and vendor bytes
    wr(9'h000, 32'h0000_3FFF, 4'b0011);
    chk(32'(cmd_stb_o), 32'h1, "R13 strobe ch0");
    chk(32'(cmd_data_o[7:0]), 32'hFF, "R13 byte ch0");
    rd(9'h000, 32'h0000_3F09, "R2 cmd/vendor ch0");
    chk(32'(cmd_stb_o), 32'h0, "R13 strobe one cycle");
    wr(9'h008, 32'h0000_0541, 4'b0011);
    chk(32'(cmd_stb_o), 32'h2, "R13 strobe ch1");
    chk(32'(cmd_data_o[15:8]), 32'h41, "R13 byte ch1");
    rd(9'h008, 32'h0000_0501, "R2 cmd/vendor ch1");
    wr(9'h004, 32'hDEAD_BEEF, 4'b1111);
    wr(9'h004, 32'h1122_3344, 4'b0100);
    rd(9'h004, 32'hDE22_BEEF, "R2 descriptor lanes");
    wr(9'h00C, 32'h1234_5678, 4'b1111);
    rd(9'h00C, 32'h1234_5678, "R2 descriptor ch1");

    // R3 status write semantics
    wr(9'h000, 32'h00FF_0000, 4'b0100);
    rd(9'h000, 32'h0060_3F09, "R3 status write");
    wr(9'h000, 32'hFF00_0000, 4'b1000);
    rd(9'h000, 32'h0060_3F09, "R2 lane3 ignored");

    // R4 engine inputs
    pulse(int_set, 2'b01);
    pulse(err_set, 2'b01);
    @(negedge clk) act = 2'b01;
    rd(9'h000, 32'h0067_3F09, "R4 sets and active");
    wr(9'h000, 32'h0004_0000, 4'b0100);
    rd(9'h000, 32'h0003_3F09, "R3 w1c bit2");
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 9'h000; wdata = 32'h0002_0000; be = 4'b0100; err_set = 2'b01;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0; err_set = '0;
    rd(9'h000, 32'h0003_3F09, "R4 set wins over clear");
    wr(9'h000, 32'h0002_0000, 4'b0100);
    rd(9'h000, 32'h0001_3F09, "R3 w1c bit1");

    // R5 aliases
    wr(9'h010, 32'h0060_0A00, 4'b0110);
    chk(32'(cmd_stb_o), 32'h0, "R13 no strobe without lane0");
    rd(9'h000, 32'h0061_0A09, "R5 alias ch0");
    wr(9'h018, 32'h0000_2300, 4'b0010);
    rd(9'h008, 32'h0000_2301, "R5 alias ch1 vendor");
    wr(9'h018, 32'h0000_0008, 4'b0001);
    chk(32'(cmd_stb_o), 32'h2, "R5 alias cmd strobe ch1");

    // R6 / R7 / R8 / R9 combined views and interrupts
    pulse(int_set, 2'b10);
    @(negedge clk) irq_in = 2'b11;
    @(negedge clk);
    chk(32'(irq_o), 32'h1, "R9 irq both");
    rd(9'h010, 32'h0461_4059, "R6 combined both irq");
    rd(9'h018, 32'h0004_0018, "R7 combined ch1 irq");
    rd(9'h0A0, 32'h6515_0800, "R8 cfg0 flag");
    rd(9'h0E0, 32'h6515_0800, "R8 cfg1 flag");
    @(negedge clk) irq_in = 2'b01;
    @(negedge clk);
    chk(32'(irq_o), 32'h1, "R9 irq ch0 only");
    rd(9'h010, 32'h0461_4019, "R6 combined ch0 irq");
    rd(9'h018, 32'h0004_0008, "R7 combined no irq");
    @(negedge clk) irq_in = 2'b00;
    @(negedge clk);
    chk(32'(irq_o), 32'h0, "R9 irq cleared");
    rd(9'h0A0, 32'h6515_0000, "R8 cfg0 flag cleared");

    // R10 link control
    wr(9'h100, 32'hFFFF_F001, 4'b0011);
    chk(32'(chan_rst_o), 32'h1, "R10 pulse ch0");
    rd(9'h100, 32'h0000_0001, "R10 lc0 12 bits");
    chk(32'(chan_rst_o), 32'h0, "R10 pulse one cycle");
    wr(9'h180, 32'h0000_0ABE, 4'b0011);
    chk(32'(chan_rst_o), 32'h0, "R10 no pulse bit0 low");
    rd(9'h180, 32'h0000_0ABE, "R10 lc1");
    wr(9'h180, 32'h0000_0001, 4'b0010);
    chk(32'(chan_rst_o), 32'h0, "R10 no pulse lane0 off");
    rd(9'h180, 32'h0000_00BE, "R10 lc1 upper lane");

    // R11 interrupt enable
    wr(9'h148, 32'hFFFF_1234, 4'b1111);
    rd(9'h148, 32'h3EED_0000, "R11 ie0 mask");
    wr(9'h1C8, 32'h1234_0000, 4'b1000);
    rd(9'h1C8, 32'h1200_0000, "R11 ie1 upper lane");

    // R12 link status
    @(negedge clk) present = 2'b10;
    rd(9'h104, 32'h0, "R12 ch0 absent");
    rd(9'h184, 32'h0000_0113, "R12 ch1 present");

    // R1 unmapped and misaligned
    wr(9'h1FC, 32'hFFFF_FFFF, 4'b1111);
    chk(32'(rvalid_o), 32'h0, "R1 no rvalid on write");
    rd(9'h1FC, 32'h0, "R1 unmapped read");
    rd(9'h014, 32'h0, "R1 unmapped gap");
    wr(9'h001, 32'hFFFF_FFFF, 4'b1111);
    rd(9'h001, 32'h0, "R1 misaligned read");
    rd(9'h000, 32'h0061_0A09, "R1 writes ignored");

    // R14 task-file windows
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 9'h084;
    exp_q.push_back(32'h0); tag_q.push_back("R14 tf read data");
    #1 chk(32'({tf_we_o, tf_sel_o}), 32'h1, "R14 tf0 read select");
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 9'h0C8; be = 4'b1111;
    #1 chk(32'({tf_we_o, tf_sel_o}), 32'h6, "R14 tf1 write select");
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
    #1 chk(32'(tf_sel_o), 32'h0, "R14 idle select");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1: actual %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule